// File: doc/BRIEF.md
# Amplifier Control Register File

This block is a two-wire serial (I2C) target that holds the configuration of a stereo power amplifier in three 8-bit registers: channel mute, power-down, and path control. A host writes a register by addressing the target, sending a register pointer and then a data byte. It reads a register by sending the pointer, issuing a repeated start with the read bit set, and clocking the byte back out.

The decoded control lines are driven from the register contents: left and right mute, power-down, input-source select, gain select and the speaker/headphone mode. While headphone auto-detection is enabled, the mode and gain come from an external headphone-sense pin. Otherwise they come from two control bits. Writing a power-down byte whose upper six bits are all ones restores every register to zero instead of storing the byte.

The SCL and SDA pins are synchronized with two flops each before edge detection. SDA is driven only low, through an output enable.

Top module: `amp_ctrl_regs`

## Requirements
- R1: The target acknowledges only the address given by parameter DEV_ADDR (7'h4D by default). For any other address it never pulls SDA low, and the rest of that transfer changes nothing.
- R2: A write of the form address+W, pointer, data is acknowledged on all three bytes. The data byte is stored when its eighth bit ends.
- R3: A read of the form address+W, pointer, repeated start, address+R returns the selected register MSB first. Pointers outside 0x01..0x03 are acknowledged, but writes to them are dropped and reads from them return 0x00.
- R4: Register 0x01 bit 3 drives mute_left and bit 4 drives mute_right. A 1 mutes the channel.
- R5: Register 0x02 bit 0 drives shutdown. A 1 powers the amplifier down.
- R6: A byte written to pointer 0x02 with bits 7..2 all set clears all three registers to 0x00 and is not stored. Any other byte written to 0x02 is stored normally.
- R7: Register 0x03 bit 1 drives in_sel1. A 1 selects input 1 and a 0 selects input 2.
- R8: With register 0x03 bit 2 set (manual mode), spk_mode equals bit 4 and gain_b equals bit 3, and hp_sense has no effect.
- R9: With register 0x03 bit 2 clear (auto mode), spk_mode is the inverse of hp_sense and gain_b equals hp_sense. Bits 3 and 4 have no effect.
- R10: After reset all three registers read 0x00. The outputs are then: both channels unmuted, not shut down, input 2, auto mode.
- R11: A stop condition in the middle of a data byte abandons the transfer, and the register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| hp_sense | input | 1 | Headphone plugged in when 1 |
| mute_left | output | 1 | Left channel muted |
| mute_right | output | 1 | Right channel muted |
| shutdown | output | 1 | Amplifier powered down |
| in_sel1 | output | 1 | Input 1 selected when 1, input 2 when 0 |
| gain_b | output | 1 | Gain setting B when 1, A when 0 |
| spk_mode | output | 1 | Speaker mode when 1, headphone mode when 0 |

## Verification
A stored byte lands one clock after the synchronized falling SCL edge that closes its eighth bit, which is about three clocks after the pin falls. The outputs derived from that byte follow in the same clock. The gain and mode outputs are combinational in hp_sense, so they settle within a clock of a sense change. The bench samples SDA a quarter SCL period after each rising SCL edge, which is well past the three-clock lag of the acknowledge and read-data drive. It checks the control outputs only after a full stop condition, or a few clocks after it changes hp_sense, and always on the falling system-clock edge.

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h4D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic hp_sense,
  output logic mute_left,
  output logic mute_right,
  output logic shutdown,
  output logic in_sel1,
  output logic gain_b,
  output logic spk_mode
);
  localparam logic [7:0] P_MUTE = 8'h01;
  localparam logic [7:0] P_PWR  = 8'h02;
  localparam logic [7:0] P_CTL  = 8'h03;
  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WR, S_RD} st_t;

  st_t        state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr, rd_val;
  logic       ack_ph, rw, mack;
  logic [7:0] r_mute, r_pwr, r_ctl;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire byte_end = fall & ~ack_ph & (bitcnt == LAST_BIT);
  wire wr_ev   = (state == S_WR) & byte_end;
  wire soft_rst = wr_ev & (ptr == P_PWR) & (&shreg[7:2]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_comb
    case (ptr)
      P_MUTE:  rd_val = r_mute;
      P_PWR:   rd_val = r_pwr;
      P_CTL:   rd_val = r_ctl;
      default: rd_val = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0;
      ack_ph <= 1'b0; rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
    end else if (start_c) begin
      state <= S_DEV; bitcnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; ack_ph <= 1'b0; sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (rise) begin
        if (ack_ph) mack <= ~sda_s;
        else if (bitcnt != LAST_BIT) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
      end
      if (fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0;
          case (state)
            S_DEV:
              if (rw) begin
                state <= S_RD; shreg <= rd_val; sda_oe <= ~rd_val[7];
              end else state <= S_REG;
            S_REG: state <= S_WR;
            S_RD:
              if (mack) begin
                shreg <= rd_val; sda_oe <= ~rd_val[7];
              end else state <= S_IDLE;
            default: ;
          endcase
        end else if (bitcnt == LAST_BIT) begin
          case (state)
            S_DEV:
              if (shreg[7:1] == DEV_ADDR) begin
                rw <= shreg[0]; ack_ph <= 1'b1; sda_oe <= 1'b1;
              end else state <= S_IDLE;
            S_REG: begin ptr <= shreg; ack_ph <= 1'b1; sda_oe <= 1'b1; end
            S_WR:  begin ack_ph <= 1'b1; sda_oe <= 1'b1; end
            S_RD:  begin ack_ph <= 1'b1; sda_oe <= 1'b0; end
            default: ;
          endcase
        end else if (state == S_RD) sda_oe <= ~shreg[7];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_mute <= '0; r_pwr <= '0; r_ctl <= '0;
    end else if (soft_rst) begin
      r_mute <= '0; r_pwr <= '0; r_ctl <= '0;
    end else if (wr_ev) begin
      case (ptr)
        P_MUTE: r_mute <= shreg;
        P_PWR:  r_pwr  <= shreg;
        P_CTL:  r_ctl  <= shreg;
        default: ;
      endcase
    end

  wire manual = r_ctl[2];

  assign mute_left  = r_mute[3];
  assign mute_right = r_mute[4];
  assign shutdown   = r_pwr[0];
  assign in_sel1    = r_ctl[1];
  assign spk_mode   = manual ? r_ctl[4] : ~hp_sense;
  assign gain_b     = manual ? r_ctl[3] : hp_sense;
endmodule

// File: rtl/amp_ctrl_regs_chk.sv
module amp_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       stop_c,
  input logic [2:0] state_q,
  input logic [7:0] ctl,
  input logic       sda_oe,
  input logic       hp_sense,
  input logic       mute_left,
  input logic       mute_right,
  input logic       shutdown,
  input logic       in_sel1,
  input logic       gain_b,
  input logic       spk_mode
);
  assert_drive_while_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  assert_cfg_moves_on_scl_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mute_left, mute_right, shutdown, in_sel1}) |-> (!scl_q && $past(scl_q)));

  assert_no_drive_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state_q != 3'd0));

  assert_release_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  assert_auto_mode_follows_sense_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[2] |-> (spk_mode != hp_sense) && (gain_b == hp_sense));

  assert_manual_ignores_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2] && $past(ctl[2]) && $stable(ctl)) |-> ($stable(spk_mode) && $stable(gain_b)));
endmodule

bind amp_ctrl_regs amp_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .stop_c(stop_c),
  .state_q(state), .ctl(r_ctl), .sda_oe(sda_oe), .hp_sense(hp_sense),
  .mute_left(mute_left), .mute_right(mute_right), .shutdown(shutdown),
  .in_sel1(in_sel1), .gain_b(gain_b), .spk_mode(spk_mode)
);

// File: tb/amp_ctrl_regs_bench.sv
module amp_ctrl_regs_bench;
  localparam logic [6:0] ADDR = 7'h4D;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_drv = 1'b1, sda_drv = 1'b1, hp = 1'b0;
  logic sda_oe, mute_left, mute_right, shutdown, in_sel1, gain_b, spk_mode;
  wire  sda_bus = sda_drv & ~sda_oe;
  int   vecs = 0, errs = 0;
  logic [7:0] m_mute = 8'h00, m_pwr = 8'h00, m_ctl = 8'h00;

  amp_ctrl_regs #(.DEV_ADDR(ADDR)) u_amp_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe(sda_oe),
    .hp_sense(hp), .mute_left(mute_left), .mute_right(mute_right),
    .shutdown(shutdown), .in_sel1(in_sel1), .gain_b(gain_b), .spk_mode(spk_mode));

  always #4 clk = ~clk;

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_drv = 1'b1; wt(Q); scl_drv = 1'b1; wt(Q); sda_drv = 1'b0; wt(Q); scl_drv = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop;
    sda_drv = 1'b0; wt(Q); scl_drv = 1'b1; wt(Q); sda_drv = 1'b1; wt(Q);
  endtask

  task automatic clk_bit(input logic b);
    sda_drv = b; wt(Q); scl_drv = 1'b1; wt(2 * Q); scl_drv = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda_drv = 1'b1; wt(Q); scl_drv = 1'b1; wt(Q); ack = ~sda_bus; wt(Q); scl_drv = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_drv = 1'b1; wt(Q); b = {b[6:0], sda_bus}; wt(Q); scl_drv = 1'b0;
    end
    wt(Q);
    clk_bit(~mack);
    sda_drv = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, output int acks);
    logic k;
    acks = 0;
    i2c_start;
    send_byte({a, 1'b0}, k);
    if (k) begin
      acks++;
      send_byte(p, k); acks += int'(k);
      send_byte(d, k); acks += int'(k);
    end
    i2c_stop;
    wt(4);
  endtask

  task automatic rd(input logic [7:0] p, output logic [7:0] d);
    logic k;
    i2c_start;
    send_byte({ADDR, 1'b0}, k);
    send_byte(p, k);
    i2c_start;
    send_byte({ADDR, 1'b1}, k);
    recv_byte(1'b0, d);
    i2c_stop;
    wt(4);
  endtask

  task automatic model_wr(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'h02 && d[7:2] == 6'h3F) begin
      m_mute = 8'h00; m_pwr = 8'h00; m_ctl = 8'h00;
    end else case (p)
      8'h01: m_mute = d;
      8'h02: m_pwr = d;
      8'h03: m_ctl = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] p);
    case (p)
      8'h01: return m_mute;
      8'h02: return m_pwr;
      8'h03: return m_ctl;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [5:0] exp_outs(input logic h);
    logic spk, gb;
    spk = m_ctl[2] ? m_ctl[4] : ~h;
    gb  = m_ctl[2] ? m_ctl[3] : h;
    return {m_mute[3], m_mute[4], m_pwr[0], m_ctl[1], gb, spk};
  endfunction

  task automatic chk_outs(input string req);
    chk(req, int'({mute_left, mute_right, shutdown, in_sel1, gain_b, spk_mode}), int'(exp_outs(hp)));
  endtask

  task automatic do_wr(input logic [7:0] p, input logic [7:0] d, input string req);
    int acks;
    wr(ADDR, p, d, acks);
    model_wr(p, d);
    chk({req, " acks"}, acks, 3);
  endtask

  task automatic chk_rd(input logic [7:0] p, input string req);
    logic [7:0] d;
    rd(p, d);
    chk(req, int'(d), int'(model_rd(p)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int acks;
    logic k;
    void'($urandom(32'd1957));
    wt(10); rst_n = 1'b1; wt(5);

    chk_outs("R10 reset outputs");
    chk_rd(8'h01, "R10 reset mute reg");
    chk_rd(8'h02, "R10 reset power reg");
    chk_rd(8'h03, "R10 reset control reg");

    do_wr(8'h01, 8'h18, "R2 write mute");
    chk_outs("R4 both muted");
    chk_rd(8'h01, "R3 read mute");
    do_wr(8'h01, 8'h08, "R2");
    chk_outs("R4 left only");

    do_wr(8'h02, 8'h01, "R2");
    chk_outs("R5 shutdown set");
    do_wr(8'h03, 8'h02, "R2");
    chk_outs("R7 input 1");

    do_wr(8'h03, 8'h18, "R2");
    hp = 1'b0; wt(3); chk_outs("R9 auto, no phones");
    hp = 1'b1; wt(3); chk_outs("R9 auto, phones in");
    do_wr(8'h03, 8'h14, "R2");
    hp = 1'b0; wt(3); chk_outs("R8 manual speaker");
    hp = 1'b1; wt(3); chk_outs("R8 manual, sense ignored");
    do_wr(8'h03, 8'h0C, "R2");
    chk_outs("R8 manual headphone gain B");

    wr(7'h22, 8'h01, 8'h00, acks);
    chk("R1 foreign address acks", acks, 0);
    chk_rd(8'h01, "R1 register untouched");

    do_wr(8'h05, 8'hAA, "R3 unused pointer");
    chk_rd(8'h05, "R3 unused pointer reads zero");
    chk_rd(8'h01, "R3 unused write dropped");

    do_wr(8'h02, 8'h7D, "R6 near-miss pattern");
    chk_rd(8'h02, "R6 near-miss stored");
    chk_rd(8'h01, "R6 near-miss no clear");
    do_wr(8'h02, 8'hFC, "R6 clear pattern");
    chk_rd(8'h01, "R6 mute cleared");
    chk_rd(8'h02, "R6 power cleared");
    chk_rd(8'h03, "R6 control cleared");
    chk_outs("R6 outputs after clear");

    do_wr(8'h01, 8'h10, "R2");
    i2c_start;
    send_byte({ADDR, 1'b0}, k);
    send_byte(8'h01, k);
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    i2c_stop; wt(4);
    chk_rd(8'h01, "R11 aborted byte");
    chk_outs("R11 outputs after abort");

    for (int n = 0; n < 45; n++) begin
      int op;
      logic [7:0] p, d;
      op = int'($urandom % 3);
      p = 8'($urandom % 5);
      d = 8'($urandom);
      if (op == 0) begin
        if (p == 8'h02 && ($urandom % 3) == 0) d = d | 8'hFC;
        do_wr(p, d, "R2 random write");
      end else if (op == 1) chk_rd(p, "R3 random read");
      else begin
        hp = 1'($urandom); wt(3);
      end
      chk_outs("R4 R5 R7 R8 R9 random outputs");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule